// File: doc/BRIEF.md
# Look-Ahead Conditional Branch Resolver

This block sits next to an instruction queue and handles the oldest conditional branch waiting in it. Each cycle it finds that branch and reads the condition field the branch tests. When the field holds its final value, the branch resolves in the same cycle, so a branch whose condition is already known adds no cycle. When an older in-flight instruction still owns the field, the block redirects fetch along the direction given by a static hint bit carried in the branch. It then waits for the field's writeback. On that cycle it either accepts the guess or raises a one-cycle flush with the corrected fetch address.

The branch target is one of three: the branch address plus an immediate offset, the link register, or the count register. All targets are word aligned. The block owns the link register, the count register and a condition register built from 4-bit fields, and each field has a busy bit. A move port copies the link and count registers to and from general registers, so resolution never waits on the integer register file. A condition writeback or a move that lands in the same cycle as a resolving branch is forwarded to that branch. The queue driver removes the entry reported by `br_done` before the next cycle, and it keeps a pending branch as the oldest branch until the branch resolves.

Top module: `lookahead_branch`

## Requirements
- R1: The selected branch is the lowest-index queue entry that has both its valid flag and its conditional-branch flag set. Entry 0 is the oldest. `br_idx` reports that entry's index whenever `br_done` is high.
- R2: If the selected branch's condition field is not busy, or is written back in the same cycle, the branch resolves in that cycle. In that cycle `br_done` is 1 and `flush` is 0. `fetch_redir` is 1 exactly when the branch is taken, and `fetch_addr` is then the target.
- R3: A branch is taken when bit `bsel` (0 = least significant) of its 4-bit condition field equals its `sense` bit. `br_taken` reports this direction in the resolving cycle.
- R4: The target depends on the 2-bit kind code. Kind 0 gives branch address plus offset, kind 1 gives the link register, and kinds 2 and 3 give the count register. Bits [1:0] of every target and of every fall-through address are forced to zero.
- R5: In the first cycle that the selected branch's field is busy, `br_done` is 0, and `fetch_redir` equals the hint bit (1 = predict taken), with `fetch_addr` set to the target.
- R6: While a predicted branch waits for its field, each further busy cycle shows `fetch_redir`, `br_done` and `flush` at 0.
- R7: When a predicted branch resolves against its hint, `flush` and `fetch_redir` are 1. `fetch_addr` is the target if the branch is taken, or the branch address plus 4 if it is not. When it resolves as predicted, neither `flush` nor `fetch_redir` is raised.
- R8: `flush` lasts one cycle and occurs only together with `br_done`.
- R9: A resolving branch with its link bit set writes the branch address plus 4 into the link register, whatever its direction. The new value is visible from the next cycle.
- R10: A claim sets a field's busy bit from the next cycle. A writeback stores the 4-bit value and clears busy. When a claim and a writeback hit the same field in one cycle, the value is stored and the field stays busy.
- R11: The move port writes the link register (select 0) or the count register (select 1). The read port returns the current register contents. Both registers reset to 0. A link write from a resolving branch wins over a move write to the link register in the same cycle.
- R12: A move write to the link or count register, and a condition writeback, that occur in the same cycle as a resolving branch are used by that branch.
- R13: With no valid conditional branch in the queue, `br_done`, `fetch_redir` and `flush` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iq_vld | input | DEPTH | Entry holds an instruction |
| iq_cbr | input | DEPTH | Entry is a conditional branch |
| iq_kind | input | 2*DEPTH | Target kind per entry |
| iq_lk | input | DEPTH | Branch writes the link register |
| iq_hint | input | DEPTH | Static prediction, 1 = taken |
| iq_fld | input | FW*DEPTH | Condition field index per entry |
| iq_bsel | input | 2*DEPTH | Bit tested within the field |
| iq_sense | input | DEPTH | Bit value that means taken |
| iq_pc | input | 32*DEPTH | Branch address per entry |
| iq_off | input | 32*DEPTH | Immediate offset per entry |
| cr_claim_en | input | 1 | Mark a field busy |
| cr_claim_fld | input | FW | Field to mark busy |
| cr_wb_en | input | 1 | Field writeback |
| cr_wb_fld | input | FW | Field written back |
| cr_wb_data | input | 4 | Written field value |
| mv_wr_en | input | 1 | Move write strobe |
| mv_wr_sel | input | 1 | 0 = link, 1 = count |
| mv_wr_data | input | 32 | Move write value |
| mv_rd_sel | input | 1 | 0 = link, 1 = count |
| mv_rd_data | output | 32 | Selected register contents |
| br_done | output | 1 | Selected branch resolved this cycle |
| br_idx | output | IW | Queue index of the selected branch |
| br_taken | output | 1 | Resolved direction |
| fetch_redir | output | 1 | Fetch must continue at fetch_addr |
| fetch_addr | output | 32 | Redirect address |
| flush | output | 1 | Wrong-path fetch must be discarded |

## Verification
Two cases put two of the block's actions in the same cycle. In the first, a condition writeback resolves a predicted branch while a move write updates the link register that the branch may read. In the second, a branch-and-link writes the link register while the move port also writes it. The bench provokes both with directed sequences. It judges the first by the redirect address and flush seen in the resolving cycle, and the second by reading the link register back through the move port one cycle later. A claim and a writeback on the same field in one cycle is also provoked. The bench then shows that the next branch on that field waits, instead of resolving at once.

// File: rtl/brl_pkg.sv
package brl_pkg;
  parameter int ADDR_W = 32;
  parameter int CRF_W  = 4;
  parameter int BSEL_W = $clog2(CRF_W);

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    TGT_REL   = 2'd0,
    TGT_LINK  = 2'd1,
    TGT_CNT   = 2'd2,
    TGT_CNT_B = 2'd3
  } tgt_kind_e;

  function automatic addr_t word_align(addr_t a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic addr_t rel_target(addr_t pc, addr_t off);
    return word_align(pc + off);
  endfunction

  function automatic addr_t fall_through(addr_t pc);
    return word_align(pc + ADDR_W'(4));
  endfunction

  function automatic logic cond_met(logic [CRF_W-1:0] f, logic [BSEL_W-1:0] sel, logic sense);
    return f[sel] == sense;
  endfunction
endpackage

// File: rtl/brl_pick.sv
module brl_pick #(
  parameter int DEPTH = 4,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] cbr,
  output logic             found,
  output logic [IW-1:0]    idx
);
  logic [DEPTH-1:0] cand;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cand
      assign cand[g] = vld[g] & cbr[g];
    end
  endgenerate

  // lowest index wins: scan from the youngest down
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/brl_crfile.sv
module brl_crfile import brl_pkg::*; #(
  parameter int NFLD = 8,
  localparam int FW = (NFLD > 1) ? $clog2(NFLD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim_en,
  input  logic [FW-1:0]    claim_fld,
  input  logic             wb_en,
  input  logic [FW-1:0]    wb_fld,
  input  logic [CRF_W-1:0] wb_data,
  input  logic [FW-1:0]    rd_fld,
  output logic [CRF_W-1:0] rd_val,
  output logic             rd_ready,
  output logic [NFLD-1:0]  busy
);
  logic [CRF_W-1:0] fld_val [NFLD];
  logic             wb_hit;

  genvar g;
  generate
    for (g = 0; g < NFLD; g++) begin : g_fld
      logic [CRF_W-1:0] val_r;
      logic             busy_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_r  <= '0;
          busy_r <= 1'b0;
        end else begin
          if (wb_en && wb_fld == FW'(g)) val_r <= wb_data;
          if (claim_en && claim_fld == FW'(g)) busy_r <= 1'b1;
          else if (wb_en && wb_fld == FW'(g)) busy_r <= 1'b0;
        end
      end
      assign fld_val[g] = val_r;
      assign busy[g]    = busy_r;
    end
  endgenerate

  // same-cycle writeback is forwarded to the reader
  assign wb_hit   = wb_en && (wb_fld == rd_fld);
  assign rd_val   = wb_hit ? wb_data : fld_val[rd_fld];
  assign rd_ready = wb_hit || !busy[rd_fld];
endmodule

// File: rtl/brl_spr.sv
module brl_spr import brl_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mv_wr_en,
  input  logic  mv_wr_sel,
  input  addr_t mv_wr_data,
  input  logic  mv_rd_sel,
  output addr_t mv_rd_data,
  input  logic  link_en,
  input  addr_t link_data,
  output addr_t lr_fwd,
  output addr_t ctr_fwd,
  output addr_t lr_cur
);
  addr_t lr_q, ctr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q  <= '0;
      ctr_q <= '0;
    end else begin
      if (link_en) lr_q <= link_data;
      else if (mv_wr_en && !mv_wr_sel) lr_q <= mv_wr_data;
      if (mv_wr_en && mv_wr_sel) ctr_q <= mv_wr_data;
    end
  end

  assign lr_fwd     = (mv_wr_en && !mv_wr_sel) ? mv_wr_data : lr_q;
  assign ctr_fwd    = (mv_wr_en &&  mv_wr_sel) ? mv_wr_data : ctr_q;
  assign mv_rd_data = mv_rd_sel ? ctr_q : lr_q;
  assign lr_cur     = lr_q;
endmodule

// File: rtl/lookahead_branch.sv
module lookahead_branch import brl_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int NFLD  = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW = (NFLD > 1) ? $clog2(NFLD) : 1,
  localparam int AW = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH-1:0]      iq_vld,
  input  logic [DEPTH-1:0]      iq_cbr,
  input  logic [2*DEPTH-1:0]    iq_kind,
  input  logic [DEPTH-1:0]      iq_lk,
  input  logic [DEPTH-1:0]      iq_hint,
  input  logic [FW*DEPTH-1:0]   iq_fld,
  input  logic [2*DEPTH-1:0]    iq_bsel,
  input  logic [DEPTH-1:0]      iq_sense,
  input  logic [AW*DEPTH-1:0]   iq_pc,
  input  logic [AW*DEPTH-1:0]   iq_off,
  input  logic                  cr_claim_en,
  input  logic [FW-1:0]         cr_claim_fld,
  input  logic                  cr_wb_en,
  input  logic [FW-1:0]         cr_wb_fld,
  input  logic [3:0]            cr_wb_data,
  input  logic                  mv_wr_en,
  input  logic                  mv_wr_sel,
  input  logic [AW-1:0]         mv_wr_data,
  input  logic                  mv_rd_sel,
  output logic [AW-1:0]         mv_rd_data,
  output logic                  br_done,
  output logic [IW-1:0]         br_idx,
  output logic                  br_taken,
  output logic                  fetch_redir,
  output logic [AW-1:0]         fetch_addr,
  output logic                  flush
);
  // selection
  logic          found;
  logic [IW-1:0] sel;
  int            si;

  brl_pick #(.DEPTH(DEPTH)) u_pick (
    .vld(iq_vld), .cbr(iq_cbr), .found(found), .idx(sel)
  );

  tgt_kind_e         s_kind;
  logic              s_lk, s_hint, s_sense;
  logic [FW-1:0]     s_fld;
  logic [BSEL_W-1:0] s_bsel;
  addr_t             s_pc, s_off;

  always_comb begin
    si      = int'(sel);
    s_kind  = tgt_kind_e'(iq_kind[si*2 +: 2]);
    s_lk    = iq_lk[si];
    s_hint  = iq_hint[si];
    s_sense = iq_sense[si];
    s_fld   = iq_fld[si*FW +: FW];
    s_bsel  = iq_bsel[si*BSEL_W +: BSEL_W];
    s_pc    = iq_pc[si*AW +: AW];
    s_off   = iq_off[si*AW +: AW];
  end

  // condition register with scoreboard
  logic [CRF_W-1:0] cr_val;
  logic             cr_ready;
  logic [NFLD-1:0]  cr_busy;

  brl_crfile #(.NFLD(NFLD)) u_cr (
    .clk(clk), .rst_n(rst_n),
    .claim_en(cr_claim_en), .claim_fld(cr_claim_fld),
    .wb_en(cr_wb_en), .wb_fld(cr_wb_fld), .wb_data(cr_wb_data),
    .rd_fld(s_fld), .rd_val(cr_val), .rd_ready(cr_ready), .busy(cr_busy)
  );

  // link / count registers
  logic  link_en;
  addr_t seq_addr, lr_fwd, ctr_fwd, lr_cur;

  brl_spr u_spr (
    .clk(clk), .rst_n(rst_n),
    .mv_wr_en(mv_wr_en), .mv_wr_sel(mv_wr_sel), .mv_wr_data(mv_wr_data),
    .mv_rd_sel(mv_rd_sel), .mv_rd_data(mv_rd_data),
    .link_en(link_en), .link_data(seq_addr),
    .lr_fwd(lr_fwd), .ctr_fwd(ctr_fwd), .lr_cur(lr_cur)
  );

  // target and direction
  addr_t tgt;
  logic  act_taken;

  always_comb begin
    case (s_kind)
      TGT_REL:  tgt = rel_target(s_pc, s_off);
      TGT_LINK: tgt = word_align(lr_fwd);
      default:  tgt = word_align(ctr_fwd);
    endcase
  end

  assign seq_addr  = fall_through(s_pc);
  assign act_taken = cond_met(cr_val, s_bsel, s_sense);

  // resolution events
  logic pend_q, pred_q;
  logic resolve, predict_now, mispredict;

  assign resolve     = found && cr_ready;
  assign predict_now = found && !cr_ready && !pend_q;
  assign mispredict  = resolve && pend_q && (act_taken != pred_q);
  assign link_en     = resolve && s_lk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pred_q <= 1'b0;
    end else if (resolve) begin
      pend_q <= 1'b0;
    end else if (predict_now) begin
      pend_q <= 1'b1;
      pred_q <= s_hint;
    end
  end

  always_comb begin
    fetch_redir = 1'b0;
    fetch_addr  = tgt;
    if (resolve) begin
      if (pend_q) begin
        fetch_redir = mispredict;
        fetch_addr  = act_taken ? tgt : seq_addr;
      end else begin
        fetch_redir = act_taken;
      end
    end else if (predict_now) begin
      fetch_redir = s_hint;
    end
  end

  assign flush    = mispredict;
  assign br_done  = resolve;
  assign br_idx   = sel;
  assign br_taken = resolve && act_taken;
endmodule

// File: rtl/lookahead_branch_chk.sv
module lookahead_branch_chk import brl_pkg::*; #(
  parameter int NFLD = 8,
  parameter int FW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            found,
  input logic            pend_q,
  input logic            br_done,
  input logic            fetch_redir,
  input logic            flush,
  input logic            s_lk,
  input logic [FW-1:0]   s_fld,
  input addr_t           seq_addr,
  input addr_t           lr_cur,
  input logic [NFLD-1:0] cr_busy,
  input logic            cr_claim_en,
  input logic [FW-1:0]   cr_claim_fld,
  input logic            cr_wb_en,
  input logic [FW-1:0]   cr_wb_fld
);
  assert_resolve_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> (!cr_busy[s_fld] || (cr_wb_en && cr_wb_fld == s_fld)));

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !br_done) |-> (!fetch_redir && !flush));

  assert_flush_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (br_done && pend_q && fetch_redir));

  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  assert_link_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_done && s_lk) |=> (lr_cur == $past(seq_addr)));

  assert_claim_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cr_claim_en |=> cr_busy[$past(cr_claim_fld)]);

  assert_wb_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_wb_en && !(cr_claim_en && cr_claim_fld == cr_wb_fld)) |=> !cr_busy[$past(cr_wb_fld)]);

  assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !found |-> (!br_done && !fetch_redir && !flush));
endmodule

bind lookahead_branch lookahead_branch_chk #(.NFLD(NFLD), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .found(found), .pend_q(pend_q),
  .br_done(br_done), .fetch_redir(fetch_redir), .flush(flush),
  .s_lk(s_lk), .s_fld(s_fld), .seq_addr(seq_addr), .lr_cur(lr_cur),
  .cr_busy(cr_busy), .cr_claim_en(cr_claim_en), .cr_claim_fld(cr_claim_fld),
  .cr_wb_en(cr_wb_en), .cr_wb_fld(cr_wb_fld)
);

// File: tb/lookahead_branch_tb.sv
module lookahead_branch_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [D-1:0]    iq_vld, iq_cbr, iq_lk, iq_hint, iq_sense;
  logic [2*D-1:0]  iq_kind, iq_bsel;
  logic [3*D-1:0]  iq_fld;
  logic [32*D-1:0] iq_pc, iq_off;
  logic        cr_claim_en, cr_wb_en, mv_wr_en, mv_wr_sel, mv_rd_sel;
  logic [2:0]  cr_claim_fld, cr_wb_fld;
  logic [3:0]  cr_wb_data;
  logic [31:0] mv_wr_data, mv_rd_data, fetch_addr;
  logic        br_done, br_taken, fetch_redir, flush;
  logic [1:0]  br_idx;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  lookahead_branch u_dut (
    .clk(clk), .rst_n(rst_n),
    .iq_vld(iq_vld), .iq_cbr(iq_cbr), .iq_kind(iq_kind), .iq_lk(iq_lk),
    .iq_hint(iq_hint), .iq_fld(iq_fld), .iq_bsel(iq_bsel), .iq_sense(iq_sense),
    .iq_pc(iq_pc), .iq_off(iq_off),
    .cr_claim_en(cr_claim_en), .cr_claim_fld(cr_claim_fld),
    .cr_wb_en(cr_wb_en), .cr_wb_fld(cr_wb_fld), .cr_wb_data(cr_wb_data),
    .mv_wr_en(mv_wr_en), .mv_wr_sel(mv_wr_sel), .mv_wr_data(mv_wr_data),
    .mv_rd_sel(mv_rd_sel), .mv_rd_data(mv_rd_data),
    .br_done(br_done), .br_idx(br_idx), .br_taken(br_taken),
    .fetch_redir(fetch_redir), .fetch_addr(fetch_addr), .flush(flush)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // done, taken, redirect, flush; address only when a redirect is expected
  task automatic expect_out(string tag, logic d, logic t, logic r, logic f, logic [31:0] a);
    chk({tag, " done"},  32'(br_done), 32'(d));
    chk({tag, " taken"}, 32'(br_taken), 32'(t));
    chk({tag, " redir"}, 32'(fetch_redir), 32'(r));
    chk({tag, " flush"}, 32'(flush), 32'(f));
    if (r) chk({tag, " addr"}, fetch_addr, a);
  endtask

  task automatic clr_q();
    iq_vld = '0; iq_cbr = '0; iq_kind = '0; iq_lk = '0; iq_hint = '0;
    iq_fld = '0; iq_bsel = '0; iq_sense = '0; iq_pc = '0; iq_off = '0;
  endtask

  task automatic put(int i, logic [1:0] k, logic lk, logic h, logic [2:0] f,
                     logic [1:0] b, logic s, logic [31:0] pc, logic [31:0] off);
    iq_vld[i] = 1'b1; iq_cbr[i] = 1'b1; iq_kind[i*2 +: 2] = k; iq_lk[i] = lk;
    iq_hint[i] = h; iq_fld[i*3 +: 3] = f; iq_bsel[i*2 +: 2] = b; iq_sense[i] = s;
    iq_pc[i*32 +: 32] = pc; iq_off[i*32 +: 32] = off;
  endtask

  task automatic put_plain(int i);
    iq_vld[i] = 1'b1; iq_cbr[i] = 1'b0;
  endtask

  // advance one clock, leave inputs just after the edge, drop strobes
  task automatic tick();
    @(posedge clk);
    #1;
    cr_claim_en = 1'b0; cr_wb_en = 1'b0; mv_wr_en = 1'b0;
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic wb(logic [2:0] f, logic [3:0] v);
    cr_wb_en = 1'b1; cr_wb_fld = f; cr_wb_data = v;
  endtask

  task automatic claim(logic [2:0] f);
    cr_claim_en = 1'b1; cr_claim_fld = f;
  endtask

  task automatic t_reset();
    settle();
    expect_out("R13 reset idle", 0, 0, 0, 0, 0);
    mv_rd_sel = 1'b0; settle(); chk("R11 reset link", mv_rd_data, 32'h0);
    mv_rd_sel = 1'b1; settle(); chk("R11 reset count", mv_rd_data, 32'h0);
  endtask

  task automatic t_move();
    mv_wr_en = 1'b1; mv_wr_sel = 1'b0; mv_wr_data = 32'h0000_1003; tick();
    mv_wr_en = 1'b1; mv_wr_sel = 1'b1; mv_wr_data = 32'h0000_2006; tick();
    mv_rd_sel = 1'b0; settle(); chk("R11 move link", mv_rd_data, 32'h0000_1003);
    mv_rd_sel = 1'b1; settle(); chk("R11 move count", mv_rd_data, 32'h0000_2006);
    wb(3'd2, 4'b0010); tick();   // field 2 = 0010
  endtask

  task automatic t_zero_cycle();
    clr_q(); put_plain(0); put(1, 2'd0, 0, 0, 3'd2, 2'd1, 1, 32'h100, 32'h40);
    put(2, 2'd0, 0, 0, 3'd2, 2'd1, 1, 32'h900, 32'h4);
    iq_cbr[3] = 1'b1;
    settle();
    expect_out("R2 zero-cycle taken", 1, 1, 1, 0, 32'h140);
    chk("R1 oldest idx", 32'(br_idx), 32'd1);
    tick();
    clr_q(); iq_cbr[0] = 1'b1; put_plain(1); put(2, 2'd0, 0, 0, 3'd2, 2'd1, 1, 32'h900, 32'h4);
    settle();
    chk("R1 skip invalid idx", 32'(br_idx), 32'd2);
    expect_out("R1 skip invalid", 1, 1, 1, 0, 32'h904);
    tick();
  endtask

  task automatic t_condition();
    clr_q(); put(0, 2'd0, 0, 0, 3'd2, 2'd1, 0, 32'h100, 32'h40);
    settle(); expect_out("R3 bit1 sense0 not taken", 1, 0, 0, 0, 0);
    tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd2, 2'd0, 0, 32'h100, 32'h40);
    settle(); expect_out("R3 bit0 sense0 taken", 1, 1, 1, 0, 32'h140);
    tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd2, 2'd0, 1, 32'h100, 32'h40);
    settle(); expect_out("R3 bit0 sense1 not taken", 1, 0, 0, 0, 0);
    tick();
  endtask

  task automatic t_targets();
    clr_q(); put(0, 2'd1, 0, 0, 3'd2, 2'd1, 1, 32'h100, 32'h40);
    settle(); expect_out("R4 link target", 1, 1, 1, 0, 32'h1000);
    tick();
    clr_q(); put(0, 2'd2, 0, 0, 3'd2, 2'd1, 1, 32'h100, 32'h40);
    settle(); expect_out("R4 count target", 1, 1, 1, 0, 32'h2004);
    tick();
    clr_q(); put(0, 2'd3, 0, 0, 3'd2, 2'd1, 1, 32'h100, 32'h40);
    settle(); expect_out("R4 kind3 count target", 1, 1, 1, 0, 32'h2004);
    tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd2, 2'd1, 1, 32'h200, 32'h13);
    settle(); expect_out("R4 relative aligned", 1, 1, 1, 0, 32'h210);
    tick();
  endtask

  task automatic t_forward();
    clr_q(); put(0, 2'd1, 0, 0, 3'd2, 2'd1, 1, 32'h100, 32'h40);
    mv_wr_en = 1'b1; mv_wr_sel = 1'b0; mv_wr_data = 32'h0000_3000;
    settle(); expect_out("R12 move forwarded", 1, 1, 1, 0, 32'h3000);
    tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd5, 2'd3, 1, 32'h100, 32'h8);
    wb(3'd5, 4'b1000);
    settle(); expect_out("R12 condition forwarded", 1, 1, 1, 0, 32'h108);
    tick();
    clr_q();
  endtask

  task automatic t_predict_ok();
    claim(3'd3); tick();
    clr_q(); put(0, 2'd0, 0, 1, 3'd3, 2'd2, 1, 32'h300, 32'h100);
    settle(); expect_out("R5 predict taken", 0, 0, 1, 0, 32'h400);
    tick(); settle(); expect_out("R6 waiting", 0, 0, 0, 0, 0);
    tick(); wb(3'd3, 4'b0100);
    settle(); expect_out("R7 correct prediction", 1, 1, 0, 0, 0);
    tick(); clr_q();
  endtask

  task automatic t_mispredict_nt();
    claim(3'd3); tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd3, 2'd2, 1, 32'h500, 32'h80);
    settle(); expect_out("R5 predict not taken", 0, 0, 0, 0, 0);
    tick(); wb(3'd3, 4'b0100);
    settle(); expect_out("R7 wrong, actually taken", 1, 1, 1, 1, 32'h580);
    tick(); clr_q(); settle();
    chk("R8 flush one cycle", 32'(flush), 32'd0);
  endtask

  task automatic t_mispredict_t();
    claim(3'd3); tick();
    clr_q(); put(0, 2'd0, 0, 1, 3'd3, 2'd2, 1, 32'h500, 32'h80);
    settle(); expect_out("R5 predict taken 2", 0, 0, 1, 0, 32'h580);
    tick(); wb(3'd3, 4'b0000);
    settle(); expect_out("R7 wrong, actually not taken", 1, 0, 1, 1, 32'h504);
    tick(); clr_q(); settle();
    chk("R8 flush one cycle 2", 32'(flush), 32'd0);
  endtask

  task automatic t_scoreboard();
    claim(3'd4); wb(3'd4, 4'b0001); tick();
    clr_q(); put(0, 2'd0, 0, 0, 3'd4, 2'd0, 1, 32'h800, 32'h20);
    wb(3'd6, 4'b0000);
    settle(); expect_out("R10 claim beats writeback", 0, 0, 0, 0, 0);
    tick(); wb(3'd4, 4'b0001);
    settle(); expect_out("R10 writeback releases", 1, 1, 1, 1, 32'h820);
    tick(); clr_q();
  endtask

  task automatic t_link();
    clr_q(); put(0, 2'd0, 1, 0, 3'd2, 2'd0, 1, 32'h600, 32'h40);
    mv_wr_en = 1'b1; mv_wr_sel = 1'b0; mv_wr_data = 32'h0000_7777;
    settle(); expect_out("R9 link branch not taken", 1, 0, 0, 0, 0);
    tick(); clr_q();
    mv_rd_sel = 1'b0; settle();
    chk("R9 R11 link written, wins over move", mv_rd_data, 32'h604);
  endtask

  task automatic t_idle();
    clr_q(); put_plain(0); put_plain(1); put_plain(2); put_plain(3);
    iq_kind = '1; iq_hint = '1;
    settle(); expect_out("R13 no branch", 0, 0, 0, 0, 0);
    tick(); clr_q();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL timeout: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clr_q();
    cr_claim_en = 1'b0; cr_claim_fld = '0; cr_wb_en = 1'b0; cr_wb_fld = '0;
    cr_wb_data = '0; mv_wr_en = 1'b0; mv_wr_sel = 1'b0; mv_wr_data = '0; mv_rd_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_move();
    t_zero_cycle();
    t_condition();
    t_targets();
    t_forward();
    t_predict_ok();
    t_mispredict_nt();
    t_mispredict_t();
    t_scoreboard();
    t_link();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule